// File: doc/BRIEF.md
# Watchdog timer with unlock sequences

This block is a watchdog peripheral with a simple register port on a fast bus clock and a counter that lives in a slow timer clock domain. Once armed, the counter climbs from a software-chosen load value, advancing on every timer-clock cycle or on every 2^ratio cycles when the prescaler is switched on. If software fails to restart it before it rolls over from all ones to zero, the block drives a reset pulse, reloads the counter from the load value and keeps running.

Each register write is posted. The bus side captures the word, raises a busy flag for that register and hands the word to the timer domain through a toggle handshake. The flag drops only after the write has taken effect there. Running and stopping are each guarded by an ordered pair of key words. A restart (a "kick") happens only when the trigger register receives a word different from the one it last held, so a stuck bus that repeats one value cannot keep the timer alive.

Top module: `wdt_unlock_timer`

## Requirements
- R1: After reset the counter reads 0, the pending register reads 0, the reset output is low and the timer is stopped.
- R2: Writing 0x0000BBBB and then 0x00004444 to the sequence register (word offset 3) starts the timer, which then advances the counter by one on each prescaled tick.
- R3: Writing 0x0000AAAA and then 0x00005555 to the sequence register stops the timer. While stopped, the counter holds its value unless a kick reloads it.
- R4: A write of 0xBBBB or 0xAAAA to the sequence register always arms its own pair. Any other word that does not complete the armed pair clears the armed state and leaves the run state unchanged.
- R5: A write to the trigger register (offset 2) copies the load register into the counter only if the word differs from the trigger's stored word, which is 0 after reset. Writing the load register alone never changes the counter.
- R6: The pending register (offset 5) shows one busy bit per register: bit 0 control, bit 2 load, bit 3 trigger, bit 4 sequence. A bit sets on the bus write and clears once the write has taken effect. A write to a register whose bit is set is dropped.
- R7: Control register (offset 0): bit 5 enables the prescaler and bits 4:2 hold the ratio. When enabled, the counter ticks once per 2^ratio timer clocks. When disabled, it ticks on every timer clock.
- R8: Writes to the control register and the load register (offset 1) are dropped while the timer is running.
- R9: Offset 4 reads back the counter value, resynchronised into the bus domain.
- R10: When the running counter wraps from all ones, the reset output goes high for RST_CYC timer clocks (default 4), the counter reloads from the load register, and counting continues so the next wrap comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low |
| tclk | input | 1 | Slow timer clock |
| trst_n | input | 1 | Timer-domain reset, active low |
| wr_en | input | 1 | Register write strobe, one bus cycle |
| wr_addr | input | AW (3) | Word offset of the write |
| wr_data | input | DW (32) | Write data |
| rd_addr | input | AW (3) | Word offset of the read |
| rd_data | output | DW (32) | Read data; offsets other than 4 and 5 read zero |
| wdt_rst | output | 1 | Reset pulse, timer domain |

## Verification
A detector stuck in an armed state, or one that accepts a half sequence, shows up as a counter that moves (or stays frozen) across a window of a few hundred timer clocks. The bench brackets that window by stopping the timer and reading the counter back. A wrong prescaler ratio or a missed reload moves the counter value after a fixed run, or shifts when the reset pulses appear, by a whole factor. A handshake flag that clears too early or too late is visible in the pending register within a few bus cycles of the write. It also shows as a second, back-to-back write landing when it should have been dropped.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
   // register word offsets
   localparam int unsigned OFF_CTRL  = 0;
   localparam int unsigned OFF_LOAD  = 1;
   localparam int unsigned OFF_TRIG  = 2;
   localparam int unsigned OFF_SEQ   = 3;
   localparam int unsigned OFF_COUNT = 4;
   localparam int unsigned OFF_PEND  = 5;
   // busy bit positions in the pending register
   localparam int unsigned PB_CTRL = 0;
   localparam int unsigned PB_LOAD = 2;
   localparam int unsigned PB_TRIG = 3;
   localparam int unsigned PB_SEQ  = 4;
   // posted channels: 0 ctrl, 1 load, 2 trig, 3 seq
   localparam int unsigned NCH = 4;
   // key words
   localparam logic [15:0] KEY_RUN_1  = 16'hBBBB;
   localparam logic [15:0] KEY_RUN_2  = 16'h4444;
   localparam logic [15:0] KEY_HALT_1 = 16'hAAAA;
   localparam logic [15:0] KEY_HALT_2 = 16'h5555;

   typedef enum logic [1:0] {SQ_IDLE, SQ_ARM_RUN, SQ_ARM_HALT} seq_st_e;

   function automatic int unsigned chan_off(input int unsigned idx);
      case (idx)
         0: chan_off = OFF_CTRL;
         1: chan_off = OFF_LOAD;
         2: chan_off = OFF_TRIG;
         default: chan_off = OFF_SEQ;
      endcase
   endfunction

   function automatic int unsigned chan_bit(input int unsigned idx);
      case (idx)
         0: chan_bit = PB_CTRL;
         1: chan_bit = PB_LOAD;
         2: chan_bit = PB_TRIG;
         default: chan_bit = PB_SEQ;
      endcase
   endfunction
endpackage

// File: rtl/wdt_post_chan.sv
`timescale 1ns/1ps
module wdt_post_chan #(
   parameter int unsigned DW = 32,
   parameter int unsigned SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   input  logic          tclk,
   input  logic          trst_n,
   output logic          apply,
   output logic [DW-1:0] tdata
);
   generate
      if (SYNC < 2) begin : g_bad_sync
         $error("wdt_post_chan: SYNC must be at least 2");
      end
   endgenerate

   logic          req_tog;
   logic [DW-1:0] hold_q;
   logic [SYNC-1:0] ack_sync;
   logic [SYNC:0]   req_sync;

   // bus side: capture and toggle, only when idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tog  <= 1'b0;
         hold_q   <= '0;
         ack_sync <= '0;
      end else begin
         ack_sync <= {ack_sync[SYNC-2:0], req_sync[SYNC]};
         if (wr && !busy) begin
            hold_q  <= wdata;
            req_tog <= ~req_tog;
         end
      end
   end

   assign busy = req_tog ^ ack_sync[SYNC-1];

   // timer side: last stage doubles as the acknowledge
   always_ff @(posedge tclk or negedge trst_n) begin
      if (!trst_n) req_sync <= '0;
      else         req_sync <= {req_sync[SYNC-1:0], req_tog};
   end

   assign apply = req_sync[SYNC-1] ^ req_sync[SYNC];
   assign tdata = hold_q;
endmodule

// File: rtl/wdt_seq_det.sv
`timescale 1ns/1ps
module wdt_seq_det
   import wdt_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          tclk,
   input  logic          trst_n,
   input  logic          apply,
   input  logic [DW-1:0] data,
   output logic          run_p,
   output logic          halt_p,
   output logic          armed_run
);
   seq_st_e st_q, st_d;
   logic is_run1, is_run2, is_halt1, is_halt2;

   assign is_run1  = (data == DW'(KEY_RUN_1));
   assign is_run2  = (data == DW'(KEY_RUN_2));
   assign is_halt1 = (data == DW'(KEY_HALT_1));
   assign is_halt2 = (data == DW'(KEY_HALT_2));

   assign run_p     = apply && (st_q == SQ_ARM_RUN)  && is_run2;
   assign halt_p    = apply && (st_q == SQ_ARM_HALT) && is_halt2;
   assign armed_run = (st_q == SQ_ARM_RUN);

   always_comb begin
      st_d = st_q;
      if (apply) begin
         if (is_run1)       st_d = SQ_ARM_RUN;
         else if (is_halt1) st_d = SQ_ARM_HALT;
         else               st_d = SQ_IDLE;
      end
   end

   always_ff @(posedge tclk or negedge trst_n) begin
      if (!trst_n) st_q <= SQ_IDLE;
      else         st_q <= st_d;
   end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core #(
   parameter int unsigned DW = 32,
   parameter int unsigned CW = 32,
   parameter int unsigned RW = 3,
   parameter int unsigned RST_CYC = 4
) (
   input  logic          tclk,
   input  logic          trst_n,
   input  logic          run_p,
   input  logic          halt_p,
   input  logic          ctrl_apply,
   input  logic [DW-1:0] ctrl_data,
   input  logic          load_apply,
   input  logic [DW-1:0] load_data,
   input  logic          trig_apply,
   input  logic [DW-1:0] trig_data,
   output logic          running,
   output logic [CW-1:0] count,
   output logic [CW-1:0] load_val,
   output logic          rst_o
);
   localparam int unsigned EN_BIT = 2 + RW;
   localparam int unsigned DIVW   = (1 << RW) - 1;
   localparam int unsigned PCW    = $clog2(RST_CYC + 1);

   logic          pre_en;
   logic [RW-1:0] ratio;
   logic [DW-1:0] trig_q;
   logic [DIVW-1:0] pdiv;
   logic [DIVW:0]   one_sh;
   logic [DIVW-1:0] div_lim;
   logic [PCW-1:0]  pcnt;
   logic tick, kick, wrap;

   assign one_sh  = (DIVW+1)'(1) << ratio;
   assign div_lim = DIVW'(one_sh - 1'b1);
   assign tick    = pre_en ? (pdiv == div_lim) : 1'b1;
   assign kick    = trig_apply && (trig_data != trig_q);
   assign wrap    = running && tick && (&count) && !kick;
   assign rst_o   = (pcnt != '0);

   always_ff @(posedge tclk or negedge trst_n) begin
      if (!trst_n) begin
         running  <= 1'b0;
         pre_en   <= 1'b0;
         ratio    <= '0;
         load_val <= '0;
         trig_q   <= '0;
         pdiv     <= '0;
         count    <= '0;
         pcnt     <= '0;
      end else begin
         if (run_p)       running <= 1'b1;
         else if (halt_p) running <= 1'b0;

         if (ctrl_apply && !running) begin
            pre_en <= ctrl_data[EN_BIT];
            ratio  <= ctrl_data[EN_BIT-1:2];
         end
         if (load_apply && !running) load_val <= load_data[CW-1:0];
         if (trig_apply) trig_q <= trig_data;

         if (!running || tick) pdiv <= '0;
         else                  pdiv <= pdiv + 1'b1;

         if (kick)                 count <= load_val;
         else if (wrap)            count <= load_val;
         else if (running && tick) count <= count + 1'b1;

         if (wrap)              pcnt <= PCW'(RST_CYC);
         else if (pcnt != '0)   pcnt <= pcnt - 1'b1;
      end
   end
endmodule

// File: rtl/wdt_unlock_timer.sv
`timescale 1ns/1ps
module wdt_unlock_timer
   import wdt_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 3,
   parameter int unsigned CW = 32,
   parameter int unsigned RW = 3,
   parameter int unsigned RST_CYC = 4,
   parameter int unsigned SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tclk,
   input  logic          trst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          wdt_rst
);
   generate
      if (CW > DW) begin : g_bad_cw
         $error("wdt_unlock_timer: CW must not exceed DW");
      end
      if (RW < 1 || RW > 4) begin : g_bad_rw
         $error("wdt_unlock_timer: RW must be 1..4");
      end
      if (2 + RW + 1 > DW) begin : g_bad_ctrl
         $error("wdt_unlock_timer: control field does not fit");
      end
      if (RST_CYC < 2) begin : g_bad_rst
         $error("wdt_unlock_timer: RST_CYC must be at least 2");
      end
      if (AW < 3) begin : g_bad_aw
         $error("wdt_unlock_timer: AW must be at least 3");
      end
   endgenerate

   localparam int unsigned PW = PB_SEQ + 1;

   logic [NCH-1:0] ch_wr, ch_busy, ch_apply;
   logic [DW-1:0]  ch_data [NCH];
   logic [PW-1:0]  pend;

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_chan
         assign ch_wr[gi] = wr_en && (wr_addr == AW'(chan_off(gi)));
         wdt_post_chan #(.DW(DW), .SYNC(SYNC)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (ch_wr[gi]),
            .wdata (wr_data),
            .busy  (ch_busy[gi]),
            .tclk  (tclk),
            .trst_n(trst_n),
            .apply (ch_apply[gi]),
            .tdata (ch_data[gi])
         );
      end
   endgenerate

   always_comb begin
      pend = '0;
      for (int i = 0; i < NCH; i++) pend[chan_bit(i)] = ch_busy[i];
   end

   logic run_p, halt_p, armed_run;
   wdt_seq_det #(.DW(DW)) u_seq (
      .tclk     (tclk),
      .trst_n   (trst_n),
      .apply    (ch_apply[3]),
      .data     (ch_data[3]),
      .run_p    (run_p),
      .halt_p   (halt_p),
      .armed_run(armed_run)
   );

   logic          core_running;
   logic [CW-1:0] core_count;
   logic [CW-1:0] core_load;
   logic          core_rst;
   wdt_core #(.DW(DW), .CW(CW), .RW(RW), .RST_CYC(RST_CYC)) u_core (
      .tclk      (tclk),
      .trst_n    (trst_n),
      .run_p     (run_p),
      .halt_p    (halt_p),
      .ctrl_apply(ch_apply[0]),
      .ctrl_data (ch_data[0]),
      .load_apply(ch_apply[1]),
      .load_data (ch_data[1]),
      .trig_apply(ch_apply[2]),
      .trig_data (ch_data[2]),
      .running   (core_running),
      .count     (core_count),
      .load_val  (core_load),
      .rst_o     (core_rst)
   );

   assign wdt_rst = core_rst;

   // counter image in the bus domain
   logic [CW-1:0] cnt_s1, cnt_s2;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_s1 <= '0;
         cnt_s2 <= '0;
      end else begin
         cnt_s1 <= core_count;
         cnt_s2 <= cnt_s1;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(OFF_COUNT))     rd_data = DW'(cnt_s2);
      else if (rd_addr == AW'(OFF_PEND)) rd_data = DW'(pend);
   end
endmodule

// File: rtl/wdt_unlock_timer_chk.sv
`timescale 1ns/1ps
module wdt_unlock_timer_chk
   import wdt_pkg::*;
#(
   parameter int unsigned AW = 3,
   parameter int unsigned CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tclk,
   input logic          trst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [4:0]    pend,
   input logic          running,
   input logic          armed_run,
   input logic          trig_apply,
   input logic [CW-1:0] count,
   input logic [CW-1:0] load_val,
   input logic          rst_o
);
   AST_START_NEEDS_ARM: assert property (@(posedge tclk) disable iff (!trst_n)
      $rose(running) |-> $past(armed_run)); // R2

   AST_STOPPED_HOLDS: assert property (@(posedge tclk) disable iff (!trst_n)
      (!running && !trig_apply) |=> $stable(count)); // R3

   AST_LOAD_LOCKED: assert property (@(posedge tclk) disable iff (!trst_n)
      running |=> $stable(load_val)); // R8

   AST_PULSE_HELD: assert property (@(posedge tclk) disable iff (!trst_n)
      $rose(rst_o) |=> rst_o); // R10

   AST_PULSE_FROM_RUN: assert property (@(posedge tclk) disable iff (!trst_n)
      $rose(rst_o) |-> $past(running)); // R10

   AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[PB_LOAD]) |-> $past(wr_en && wr_addr == AW'(OFF_LOAD))); // R6
endmodule

bind wdt_unlock_timer wdt_unlock_timer_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tclk      (tclk),
   .trst_n    (trst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .pend      (pend),
   .running   (core_running),
   .armed_run (armed_run),
   .trig_apply(ch_apply[2]),
   .count     (core_count),
   .load_val  (core_load),
   .rst_o     (core_rst)
);

// File: tb/wdt_unlock_timer_tb.sv
`timescale 1ns/1ps
module wdt_unlock_timer_tb;
   logic        clk = 1'b0, tclk = 1'b0;
   logic        rst_n = 1'b0, trst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        wdt_rst;

   always #10 clk  = ~clk;
   always #35 tclk = ~tclk;

   wdt_unlock_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tclk(tclk), .trst_n(trst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst(wdt_rst)
   );

   typedef struct {
      logic [2:0]  addr;
      logic [31:0] lo;
      logic [31:0] hi;
      int          same;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          checks = 0, errors = 0;
   int          pushed = 0, popped = 0;
   logic [31:0] last_rd = '0;

   // monitor: pops expected items and compares against the read port
   initial begin
      forever begin
         exp_t it;
         bit   ok;
         wait (q.size() > 0);
         it = q.pop_front();
         @(negedge clk) rd_addr = it.addr;
         repeat (2) @(negedge clk);
         if (it.same != 0) ok = (rd_data == last_rd);
         else              ok = (rd_data >= it.lo) && (rd_data <= it.hi);
         checks++;
         if (!ok) begin
            errors++;
            if (it.same != 0)
               $display("FAIL %s: got %h expected %h", it.tag, rd_data, last_rd);
            else
               $display("FAIL %s: got %h expected %h..%h", it.tag, rd_data, it.lo, it.hi);
         end
         last_rd = rd_data;
         popped++;
      end
   end

   task automatic expect_rd(input logic [2:0] a, input logic [31:0] lo,
                            input logic [31:0] hi, input int same, input string tag);
      exp_t it;
      int   target;
      it.addr = a; it.lo = lo; it.hi = hi; it.same = same; it.tag = tag;
      pushed++;
      target = pushed;
      q.push_back(it);
      wait (popped == target);
   endtask

   task automatic chk_val(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (12) @(posedge tclk);
   endtask

   task automatic wr_s(input logic [2:0] a, input logic [31:0] d);
      wr(a, d);
      settle();
   endtask

   task automatic run_on();
      wr_s(3'd3, 32'h0000_BBBB);
      wr_s(3'd3, 32'h0000_4444);
   endtask

   task automatic run_off();
      wr_s(3'd3, 32'h0000_AAAA);
      wr_s(3'd3, 32'h0000_5555);
   endtask

   // reset pulse monitor, sampled away from the timer edge
   int pulses = 0, cur_w = 0, last_w = 0;
   always @(negedge tclk) begin
      if (wdt_rst) cur_w++;
      else if (cur_w != 0) begin
         last_w = cur_w;
         pulses++;
         cur_w  = 0;
      end
   end

   initial begin
      #5_000_000;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100;
      rst_n = 1'b1; trst_n = 1'b1;
      settle();

      // R1 reset state
      expect_rd(3'd4, 32'h0, 32'h0, 0, "R1 counter after reset");
      expect_rd(3'd5, 32'h0, 32'h0, 0, "R1 pending after reset");
      chk_val(int'(wdt_rst), 0, "R1 reset output low");

      // R6 load busy bit, R5 load alone does not move counter
      wr(3'd1, 32'hFFFF_FFF0);
      expect_rd(3'd5, 32'h4, 32'h4, 0, "R6 load busy bit 2 set");
      settle();
      expect_rd(3'd5, 32'h0, 32'h0, 0, "R6 load busy bit cleared");
      expect_rd(3'd4, 32'h0, 32'h0, 0, "R5 load write leaves counter");

      // R5 kick with a new word, R9 readback
      wr(3'd2, 32'h1);
      expect_rd(3'd5, 32'h8, 32'h8, 0, "R6 trigger busy bit 3 set");
      settle();
      expect_rd(3'd4, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 0, "R5 R9 kick copies load");
      wr_s(3'd1, 32'hFFFF_FF00);
      wr_s(3'd2, 32'h1);
      expect_rd(3'd4, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 0, "R5 repeated trigger word ignored");
      wr_s(3'd2, 32'h2);
      expect_rd(3'd4, 32'hFFFF_FF00, 32'hFFFF_FF00, 0, "R5 changed trigger word reloads");

      // R6 write while busy is dropped
      wr(3'd1, 32'h100);
      wr(3'd1, 32'h200);
      settle();
      wr_s(3'd2, 32'h3);
      expect_rd(3'd4, 32'h100, 32'h100, 0, "R6 second load while busy dropped");

      // R4 broken sequences
      wr(3'd3, 32'h0000_BBBB);
      expect_rd(3'd5, 32'h10, 32'h10, 0, "R6 sequence busy bit 4 set");
      settle();
      wr_s(3'd3, 32'h0000_1234);
      wr_s(3'd3, 32'h0000_4444);
      wr_s(3'd3, 32'h0000_BBBB);
      wr_s(3'd3, 32'h0000_AAAA);
      wr_s(3'd3, 32'h0000_4444);
      repeat (40) @(posedge tclk);
      expect_rd(3'd4, 32'h100, 32'h100, 0, "R4 broken pairs leave timer stopped");

      // R2 start, R7 undivided rate, R3 stop and hold
      wr_s(3'd1, 32'h0);
      wr_s(3'd2, 32'h4);
      run_on();
      repeat (400) @(posedge tclk);
      run_off();
      expect_rd(3'd4, 32'd400, 32'd445, 0, "R2 R7 counter advanced one per clock");
      repeat (50) @(posedge tclk);
      expect_rd(3'd4, 32'h0, 32'h0, 1, "R3 counter held after stop");

      // R8 control and load dropped while running
      run_on();
      wr(3'd1, 32'h5000);
      wr(3'd0, 32'h0000_002C);
      settle();
      run_off();
      wr_s(3'd2, 32'h5);
      expect_rd(3'd4, 32'h0, 32'h0, 0, "R8 load write while running dropped");
      run_on();
      repeat (400) @(posedge tclk);
      run_off();
      expect_rd(3'd4, 32'd400, 32'd445, 0, "R8 control write while running dropped");

      // R7 prescaler enabled, ratio 3 -> divide by 8
      wr_s(3'd0, 32'h0000_002C);
      wr_s(3'd2, 32'h6);
      run_on();
      repeat (400) @(posedge tclk);
      run_off();
      expect_rd(3'd4, 32'd48, 32'd58, 0, "R7 prescaler divides by 2^ratio");

      // R10 overflow pulse, reload and continue
      wr_s(3'd0, 32'h0);
      wr_s(3'd1, 32'hFFFF_FF00);
      wr_s(3'd2, 32'h7);
      chk_val(pulses, 0, "R10 no pulse while stopped");
      run_on();
      repeat (200) @(posedge tclk);
      chk_val(pulses, 0, "R10 no pulse before wrap");
      repeat (100) @(posedge tclk);
      chk_val(pulses, 1, "R10 one pulse at wrap");
      chk_val(last_w, 4, "R10 pulse width in timer clocks");
      repeat (260) @(posedge tclk);
      chk_val(pulses, 2, "R10 counting resumed from load after wrap");
      run_off();
      expect_rd(3'd4, 32'hFFFF_FF00, 32'hFFFF_FFFF, 0, "R10 R9 counter within reloaded span");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule